// File: doc/BRIEF.md
# Issue Queue Wakeup and Select

This block holds instructions that are waiting to run. Each one comes in with an age, an operation class, two source physical tags and a destination tag. A slot can be occupied or empty. While a source tag has no value yet, its slot stays in a waiting state. Completing units put their destination tags on broadcast ports. Every occupied slot compares those tags against both of its sources. A source that matches is marked ready.

Each slot runs a small state machine with three states:
- `SLOT_FREE`: the slot is empty.
- `SLOT_WAIT`: the slot holds an entry and at least one source is not ready.
- `SLOT_READY`: the slot holds an entry and both sources are ready.

The transitions are named as follows:
- *load* moves FREE to WAIT, or FREE straight to READY when both sources are already ready.
- *wake* moves WAIT to READY.
- *issue* moves READY to FREE.
- *flush* moves WAIT or READY to FREE.

A selector looks at the READY entries whose class has an available unit. Each cycle it grants up to `ISS_W` of them, oldest first, with at most one grant per class. The granted entries appear on the issue ports in the same cycle, and their slots are emptied at the next clock edge.

Top module: `issue_queue`

## Requirements
- R1: After reset, no slot is occupied, `full` is 0 and every `iss_valid` bit is 0.
- R2: An accepted dispatch that arrives with both sources ready can appear on an issue port in the cycle after dispatch, provided a unit of its class is available.
- R3: While `DEPTH` entries are held, `full` is 1. A dispatch presented in that cycle is dropped and never issues.
- R4: A broadcast whose tag equals a source tag sets that source ready at the clock edge. An entry issues only when both of its sources are ready, so it can issue at the earliest in the cycle after its last source is woken.
- R5: If a dispatched source tag matches a broadcast in the dispatch cycle, that source is stored as ready.
- R6: The selected entries are the oldest eligible ones, where a smaller age is older. Port 0 carries the oldest pick, and a higher port only carries a pick when every lower port does, with a strictly larger age.
- R7: At most `ISS_W` entries issue per cycle.
- R8: An entry of class c issues only while `fu_avail[c]` is 1, and no two issue ports carry the same class in one cycle.
- R9: A slot that issues is empty from the next cycle, so an entry never issues twice.
- R10: `flush_valid` removes every held entry whose age is greater than `flush_age`. Entries with an age equal to or less than `flush_age` stay. A dispatch in the same cycle is still accepted.
- R11: A broadcast with its valid bit at 0, or with a tag that matches no source, changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_age | input | AGE_W | Age of dispatched entry |
| disp_cls | input | CLS_W | Operation class |
| disp_tag_l | input | TAG_W | Left source tag |
| disp_rdy_l | input | 1 | Left source already ready |
| disp_tag_r | input | TAG_W | Right source tag |
| disp_rdy_r | input | 1 | Right source already ready |
| disp_dst | input | TAG_W | Destination tag |
| full | output | 1 | No free slot; dispatch refused |
| bc_valid | input | NB | One valid bit per broadcast port |
| bc_tag | input | NB*TAG_W | Broadcast tags, port b at bits [b*TAG_W +: TAG_W] |
| fu_avail | input | 2**CLS_W | Unit availability per class |
| flush_valid | input | 1 | Flush request |
| flush_age | input | AGE_W | Entries older than or equal to this survive |
| iss_valid | output | ISS_W | Issue port carries an entry |
| iss_age | output | ISS_W*AGE_W | Issued ages, port k at [k*AGE_W +: AGE_W] |
| iss_cls | output | ISS_W*CLS_W | Issued classes |
| iss_tag_l | output | ISS_W*TAG_W | Issued left source tags |
| iss_tag_r | output | ISS_W*TAG_W | Issued right source tags |
| iss_dst | output | ISS_W*TAG_W | Issued destination tags |

## Verification
The ordering and double-issue properties assume that every age held in the queue is distinct. They also assume that a newly dispatched entry is always younger than every entry still held, so ages never wrap while entries are live. The stimulus satisfies this by taking ages from a counter that only counts up. Every dispatch attempt consumes a value, including a refused one, and the counter stays far below the age range for the whole run. Flush ages are drawn from ages already handed out, so a flush can only cut off a younger suffix of the entries.

// File: rtl/iq_pkg.sv
package iq_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;
endpackage

// File: rtl/iq_match.sv
module iq_match #(
    parameter int TAG_W = 6,
    parameter int NB    = 2
) (
    input  logic [TAG_W-1:0]         tag,
    input  logic [NB-1:0]            bc_valid,
    input  logic [NB-1:0][TAG_W-1:0] bc_tag,
    output logic                     hit
);
    always_comb begin
        hit = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (bc_valid[b] && (bc_tag[b] == tag)) hit = 1'b1;
        end
    end
endmodule

// File: rtl/iq_slot.sv
module iq_slot
    import iq_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int AGE_W = 10,
    parameter int CLS_W = 2,
    parameter int NB    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     grant,
    input  logic                     flush_valid,
    input  logic [AGE_W-1:0]         flush_age,
    input  logic [AGE_W-1:0]         ld_age,
    input  logic [CLS_W-1:0]         ld_cls,
    input  logic [TAG_W-1:0]         ld_tag_l,
    input  logic                     ld_rdy_l,
    input  logic [TAG_W-1:0]         ld_tag_r,
    input  logic                     ld_rdy_r,
    input  logic [TAG_W-1:0]         ld_dst,
    input  logic [NB-1:0]            bc_valid,
    input  logic [NB-1:0][TAG_W-1:0] bc_tag,
    output logic                     busy,
    output logic                     ready,
    output logic [AGE_W-1:0]         age_o,
    output logic [CLS_W-1:0]         cls_o,
    output logic [TAG_W-1:0]         tag_l_o,
    output logic [TAG_W-1:0]         tag_r_o,
    output logic [TAG_W-1:0]         dst_o
);
    slot_state_e state_q, state_d;
    logic rdy_l_q, rdy_r_q;
    logic hit_l, hit_r;
    logic kill;

    iq_match #(.TAG_W(TAG_W), .NB(NB)) u_match_l (
        .tag(tag_l_o), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit_l));
    iq_match #(.TAG_W(TAG_W), .NB(NB)) u_match_r (
        .tag(tag_r_o), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit_r));

    assign kill = flush_valid && (age_o > flush_age);

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:  if (load) state_d = (ld_rdy_l && ld_rdy_r) ? SLOT_READY : SLOT_WAIT;
            SLOT_WAIT:  begin
                if (kill) state_d = SLOT_FREE;
                else if ((rdy_l_q || hit_l) && (rdy_r_q || hit_r)) state_d = SLOT_READY;
            end
            SLOT_READY: if (kill || grant) state_d = SLOT_FREE;
            default:    state_d = SLOT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // payload and source-ready bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_l_q <= 1'b0;
            rdy_r_q <= 1'b0;
            age_o   <= '0;
            cls_o   <= '0;
            tag_l_o <= '0;
            tag_r_o <= '0;
            dst_o   <= '0;
        end else if (load) begin
            rdy_l_q <= ld_rdy_l;
            rdy_r_q <= ld_rdy_r;
            age_o   <= ld_age;
            cls_o   <= ld_cls;
            tag_l_o <= ld_tag_l;
            tag_r_o <= ld_tag_r;
            dst_o   <= ld_dst;
        end else begin
            if (hit_l) rdy_l_q <= 1'b1;
            if (hit_r) rdy_r_q <= 1'b1;
        end
    end

    // output process
    always_comb begin
        busy  = (state_q != SLOT_FREE);
        ready = (state_q == SLOT_READY);
    end
endmodule

// File: rtl/iq_select.sv
module iq_select #(
    parameter int DEPTH = 8,
    parameter int AGE_W = 10,
    parameter int CLS_W = 2,
    parameter int ISS_W = 2
) (
    input  logic [DEPTH-1:0]                      ready,
    input  logic [DEPTH-1:0][AGE_W-1:0]           age,
    input  logic [DEPTH-1:0][CLS_W-1:0]           cls,
    input  logic [(1<<CLS_W)-1:0]                 fu_avail,
    output logic [DEPTH-1:0]                      grant,
    output logic [ISS_W-1:0]                      pick_valid,
    output logic [ISS_W-1:0][$clog2(DEPTH)-1:0]   pick_idx
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int NCLS  = 1 << CLS_W;

    logic [DEPTH-1:0] taken;
    logic [NCLS-1:0]  cls_used;
    logic             found;
    logic [IDX_W-1:0] best;
    logic [AGE_W-1:0] best_age;

    // ISS_W rounds, each taking the oldest remaining entry of an unused class
    always_comb begin
        taken      = '0;
        cls_used   = ~fu_avail;
        pick_valid = '0;
        pick_idx   = '0;
        found      = 1'b0;
        best       = '0;
        best_age   = '0;
        for (int k = 0; k < ISS_W; k++) begin
            found    = 1'b0;
            best     = '0;
            best_age = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (ready[i] && !taken[i] && !cls_used[cls[i]] &&
                    (!found || (age[i] < best_age))) begin
                    found    = 1'b1;
                    best     = IDX_W'(i);
                    best_age = age[i];
                end
            end
            pick_valid[k] = found;
            pick_idx[k]   = best;
            if (found) begin
                taken[best]         = 1'b1;
                cls_used[cls[best]] = 1'b1;
            end
        end
        grant = taken;
    end
endmodule

// File: rtl/issue_queue.sv
module issue_queue #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 6,
    parameter int AGE_W = 10,
    parameter int CLS_W = 2,
    parameter int NB    = 2,
    parameter int ISS_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     disp_valid,
    input  logic [AGE_W-1:0]         disp_age,
    input  logic [CLS_W-1:0]         disp_cls,
    input  logic [TAG_W-1:0]         disp_tag_l,
    input  logic                     disp_rdy_l,
    input  logic [TAG_W-1:0]         disp_tag_r,
    input  logic                     disp_rdy_r,
    input  logic [TAG_W-1:0]         disp_dst,
    output logic                     full,
    input  logic [NB-1:0]            bc_valid,
    input  logic [NB*TAG_W-1:0]      bc_tag,
    input  logic [(1<<CLS_W)-1:0]    fu_avail,
    input  logic                     flush_valid,
    input  logic [AGE_W-1:0]         flush_age,
    output logic [ISS_W-1:0]         iss_valid,
    output logic [ISS_W*AGE_W-1:0]   iss_age,
    output logic [ISS_W*CLS_W-1:0]   iss_cls,
    output logic [ISS_W*TAG_W-1:0]   iss_tag_l,
    output logic [ISS_W*TAG_W-1:0]   iss_tag_r,
    output logic [ISS_W*TAG_W-1:0]   iss_dst
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [NB-1:0][TAG_W-1:0]    bc_tag_a;
    logic [DEPTH-1:0]            busy, ready, grant, load;
    logic [DEPTH-1:0][AGE_W-1:0] slot_age;
    logic [DEPTH-1:0][CLS_W-1:0] slot_cls;
    logic [DEPTH-1:0][TAG_W-1:0] slot_tag_l, slot_tag_r, slot_dst;
    logic [ISS_W-1:0]            pick_valid;
    logic [ISS_W-1:0][IDX_W-1:0] pick_idx;
    logic                        byp_l, byp_r;
    logic                        placed;

    assign bc_tag_a = bc_tag;
    assign full     = &busy;

    // lowest-index empty slot takes the dispatch
    always_comb begin
        load   = '0;
        placed = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (disp_valid && !busy[i] && !placed) begin
                load[i] = 1'b1;
                placed  = 1'b1;
            end
        end
    end

    iq_match #(.TAG_W(TAG_W), .NB(NB)) u_byp_l (
        .tag(disp_tag_l), .bc_valid(bc_valid), .bc_tag(bc_tag_a), .hit(byp_l));
    iq_match #(.TAG_W(TAG_W), .NB(NB)) u_byp_r (
        .tag(disp_tag_r), .bc_valid(bc_valid), .bc_tag(bc_tag_a), .hit(byp_r));

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        iq_slot #(.TAG_W(TAG_W), .AGE_W(AGE_W), .CLS_W(CLS_W), .NB(NB)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .load(load[i]), .grant(grant[i]),
            .flush_valid(flush_valid), .flush_age(flush_age),
            .ld_age(disp_age), .ld_cls(disp_cls),
            .ld_tag_l(disp_tag_l), .ld_rdy_l(disp_rdy_l || byp_l),
            .ld_tag_r(disp_tag_r), .ld_rdy_r(disp_rdy_r || byp_r),
            .ld_dst(disp_dst),
            .bc_valid(bc_valid), .bc_tag(bc_tag_a),
            .busy(busy[i]), .ready(ready[i]),
            .age_o(slot_age[i]), .cls_o(slot_cls[i]),
            .tag_l_o(slot_tag_l[i]), .tag_r_o(slot_tag_r[i]), .dst_o(slot_dst[i]));
    end

    iq_select #(.DEPTH(DEPTH), .AGE_W(AGE_W), .CLS_W(CLS_W), .ISS_W(ISS_W)) u_select (
        .ready(ready), .age(slot_age), .cls(slot_cls), .fu_avail(fu_avail),
        .grant(grant), .pick_valid(pick_valid), .pick_idx(pick_idx));

    for (genvar k = 0; k < ISS_W; k++) begin : g_port
        always_comb begin
            iss_valid[k] = pick_valid[k];
            iss_age[k*AGE_W +: AGE_W]   = pick_valid[k] ? slot_age[pick_idx[k]]   : '0;
            iss_cls[k*CLS_W +: CLS_W]   = pick_valid[k] ? slot_cls[pick_idx[k]]   : '0;
            iss_tag_l[k*TAG_W +: TAG_W] = pick_valid[k] ? slot_tag_l[pick_idx[k]] : '0;
            iss_tag_r[k*TAG_W +: TAG_W] = pick_valid[k] ? slot_tag_r[pick_idx[k]] : '0;
            iss_dst[k*TAG_W +: TAG_W]   = pick_valid[k] ? slot_dst[pick_idx[k]]   : '0;
        end
    end
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
    parameter int DEPTH = 8,
    parameter int AGE_W = 10,
    parameter int CLS_W = 2,
    parameter int ISS_W = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        disp_valid,
    input logic                        full,
    input logic                        flush_valid,
    input logic [AGE_W-1:0]            flush_age,
    input logic [(1<<CLS_W)-1:0]       fu_avail,
    input logic [DEPTH-1:0]            busy,
    input logic [DEPTH-1:0]            ready,
    input logic [DEPTH-1:0]            grant,
    input logic [DEPTH-1:0][AGE_W-1:0] slot_age,
    input logic [ISS_W-1:0]            iss_valid,
    input logic [ISS_W*AGE_W-1:0]      iss_age,
    input logic [ISS_W*CLS_W-1:0]      iss_cls
);
    AST_GRANT_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~ready) == '0); // R4

    AST_ISSUE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= ISS_W); // R7

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        full && disp_valid && !flush_valid && (grant == '0) |=> $stable(busy)); // R3

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot_chk
        AST_ISSUED_FREED: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |=> !busy[i]); // R9
        AST_FLUSH_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
            flush_valid && busy[i] && (slot_age[i] > flush_age) |=> !busy[i]); // R10
        AST_FLUSH_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            flush_valid && ready[i] && !grant[i] && (slot_age[i] <= flush_age) |=> busy[i]); // R10
    end

    for (genvar k = 0; k < ISS_W; k++) begin : g_port_chk
        AST_UNIT_AVAILABLE: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k] |-> fu_avail[iss_cls[k*CLS_W +: CLS_W]]); // R8
    end

    if (ISS_W > 1) begin : g_pair_chk
        AST_OLDEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[1] |-> iss_valid[0] &&
                (iss_age[AGE_W-1:0] < iss_age[2*AGE_W-1:AGE_W])); // R6
        AST_CLASS_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[1] && iss_valid[0] |->
                (iss_cls[CLS_W-1:0] != iss_cls[2*CLS_W-1:CLS_W])); // R8
    end
endmodule

bind issue_queue iq_checker #(
    .DEPTH(DEPTH), .AGE_W(AGE_W), .CLS_W(CLS_W), .ISS_W(ISS_W)
) u_iq_checker (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .full(full),
    .flush_valid(flush_valid), .flush_age(flush_age), .fu_avail(fu_avail),
    .busy(busy), .ready(ready), .grant(grant), .slot_age(slot_age),
    .iss_valid(iss_valid), .iss_age(iss_age), .iss_cls(iss_cls));

// File: tb/test_issue_queue.sv
`timescale 1ns/1ps
module test_issue_queue;
    localparam int DEPTH = 8, TAG_W = 6, AGE_W = 10, CLS_W = 2, NB = 2, ISS_W = 2;
    localparam int NCLS = 1 << CLS_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic disp_valid = 1'b0, disp_rdy_l = 1'b0, disp_rdy_r = 1'b0;
    logic [AGE_W-1:0] disp_age = '0, flush_age = '0;
    logic [CLS_W-1:0] disp_cls = '0;
    logic [TAG_W-1:0] disp_tag_l = '0, disp_tag_r = '0, disp_dst = '0;
    logic full;
    logic [NB-1:0] bc_valid = '0;
    logic [NB*TAG_W-1:0] bc_tag = '0;
    logic [NCLS-1:0] fu_avail = '0;
    logic flush_valid = 1'b0;
    logic [ISS_W-1:0] iss_valid;
    logic [ISS_W*AGE_W-1:0] iss_age;
    logic [ISS_W*CLS_W-1:0] iss_cls;
    logic [ISS_W*TAG_W-1:0] iss_tag_l, iss_tag_r, iss_dst;

    issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .AGE_W(AGE_W), .CLS_W(CLS_W),
                  .NB(NB), .ISS_W(ISS_W)) i_issue_queue (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_age(disp_age),
        .disp_cls(disp_cls), .disp_tag_l(disp_tag_l), .disp_rdy_l(disp_rdy_l),
        .disp_tag_r(disp_tag_r), .disp_rdy_r(disp_rdy_r), .disp_dst(disp_dst),
        .full(full), .bc_valid(bc_valid), .bc_tag(bc_tag), .fu_avail(fu_avail),
        .flush_valid(flush_valid), .flush_age(flush_age), .iss_valid(iss_valid),
        .iss_age(iss_age), .iss_cls(iss_cls), .iss_tag_l(iss_tag_l),
        .iss_tag_r(iss_tag_r), .iss_dst(iss_dst));

    always #10 clk = ~clk;

    typedef struct packed {
        logic [AGE_W-1:0] age;
        logic [CLS_W-1:0] cls;
        logic [TAG_W-1:0] tl;
        logic             rl;
        logic [TAG_W-1:0] tr;
        logic             rr;
        logic [TAG_W-1:0] dst;
    } ment_t;

    ment_t mq[$];
    int    exp_pick[ISS_W];
    int    n_checks = 0, n_err = 0, next_age = 1;
    bit    done = 1'b0;
    string cur_req = "R1";

    function automatic bit bc_hit(input logic [TAG_W-1:0] t);
        for (int b = 0; b < NB; b++)
            if (bc_valid[b] && bc_tag[b*TAG_W +: TAG_W] == t) return 1'b1;
        return 1'b0;
    endfunction

    task automatic compare();
        bit taken[DEPTH];
        bit used[NCLS];
        for (int i = 0; i < DEPTH; i++) taken[i] = 1'b0;
        for (int c = 0; c < NCLS; c++) used[c] = !fu_avail[c];
        n_checks++;
        if (full !== (mq.size() == DEPTH)) begin
            n_err++;
            $display("FAIL %s full: got %0b exp %0b", cur_req, full, mq.size() == DEPTH);
        end
        for (int k = 0; k < ISS_W; k++) begin
            int best = -1;
            logic [AGE_W+CLS_W+3*TAG_W-1:0] got, exp;
            for (int i = 0; i < mq.size(); i++)
                if (mq[i].rl && mq[i].rr && !taken[i] && !used[mq[i].cls] &&
                    (best < 0 || mq[i].age < mq[best].age)) best = i;
            exp_pick[k] = best;
            got = {iss_age[k*AGE_W +: AGE_W], iss_cls[k*CLS_W +: CLS_W],
                   iss_tag_l[k*TAG_W +: TAG_W], iss_tag_r[k*TAG_W +: TAG_W],
                   iss_dst[k*TAG_W +: TAG_W]};
            exp = '0;
            if (best >= 0) begin
                taken[best] = 1'b1;
                used[mq[best].cls] = 1'b1;
                exp = {mq[best].age, mq[best].cls, mq[best].tl, mq[best].tr, mq[best].dst};
            end
            n_checks++;
            if (iss_valid[k] !== (best >= 0) || (best >= 0 && got !== exp)) begin
                n_err++;
                $display("FAIL %s port %0d: got v=%0b %h exp v=%0b %h",
                         cur_req, k, iss_valid[k], got, best >= 0, exp);
            end
        end
    endtask

    task automatic update();
        ment_t nq[$];
        int old_sz = mq.size();
        for (int i = 0; i < old_sz; i++) begin
            bit gone = 1'b0;
            for (int k = 0; k < ISS_W; k++) if (exp_pick[k] == i) gone = 1'b1;
            if (flush_valid && mq[i].age > flush_age) gone = 1'b1;
            if (!gone) begin
                ment_t e = mq[i];
                if (bc_hit(e.tl)) e.rl = 1'b1;
                if (bc_hit(e.tr)) e.rr = 1'b1;
                nq.push_back(e);
            end
        end
        if (disp_valid && old_sz < DEPTH) begin
            ment_t e;
            e.age = disp_age; e.cls = disp_cls; e.dst = disp_dst;
            e.tl = disp_tag_l; e.rl = disp_rdy_l || bc_hit(disp_tag_l);
            e.tr = disp_tag_r; e.rr = disp_rdy_r || bc_hit(disp_tag_r);
            nq.push_back(e);
        end
        mq = nq;
    endtask

    task automatic step();
        #2;
        compare();
        @(posedge clk);
        update();
        @(negedge clk);
        disp_valid = 1'b0; bc_valid = '0; flush_valid = 1'b0;
    endtask

    task automatic put(input int cls, input int tl, input bit rl, input int tr,
                       input bit rr, input int dst);
        disp_valid = 1'b1; disp_age = AGE_W'(next_age); next_age++;
        disp_cls = CLS_W'(cls); disp_dst = TAG_W'(dst);
        disp_tag_l = TAG_W'(tl); disp_rdy_l = rl;
        disp_tag_r = TAG_W'(tr); disp_rdy_r = rr;
    endtask

    task automatic cast(input int b, input int tag);
        bc_valid[b] = 1'b1;
        bc_tag[b*TAG_W +: TAG_W] = TAG_W'(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < ISS_W; k++) exp_pick[k] = -1;
        repeat (3) @(negedge clk);
        #2;
        n_checks++; // R1: reset state
        if (iss_valid !== '0 || full !== 1'b0) begin
            n_err++;
            $display("FAIL R1 reset: got iss_valid=%b full=%b exp 0 0", iss_valid, full);
        end
        rst_n = 1'b1;
        @(negedge clk);
        step();

        // R2 R6 R7: four ready entries of distinct classes, released together
        cur_req = "R2/R6/R7";
        for (int i = 0; i < 4; i++) begin put(3 - i, 1, 1, 2, 1, 30 + i); step(); end
        fu_avail = '1;
        repeat (3) step();

        // R3: fill with waiting entries, then a refused dispatch
        cur_req = "R3";
        fu_avail = '0;
        for (int i = 0; i < DEPTH; i++) begin put(i % NCLS, 10 + i, 0, 20 + i, 0, i); step(); end
        put(0, 1, 1, 1, 1, 50); step();
        fu_avail = '1; step();

        // R11: invalid broadcast and non-matching tag leave entries waiting
        cur_req = "R11";
        bc_tag = {TAG_W'(12), TAG_W'(10)}; step();
        cast(0, 63); cast(1, 62); step();

        // R4: wake left then right sources
        cur_req = "R4";
        for (int i = 0; i < DEPTH; i += 2) begin cast(0, 10 + i); cast(1, 11 + i); step(); end
        for (int i = 0; i < DEPTH; i += 2) begin cast(0, 20 + i); cast(1, 21 + i); step(); end
        repeat (4) step();

        // R5: broadcast in the dispatch cycle
        cur_req = "R5";
        put(1, 40, 0, 41, 1, 7); cast(0, 40); step();
        repeat (2) step();

        // R8: only class 0 available, one per cycle
        cur_req = "R8";
        fu_avail = 4'b0001;
        put(0, 1, 1, 1, 1, 1); step();
        put(0, 1, 1, 1, 1, 2); step();
        put(1, 1, 1, 1, 1, 3); step();
        repeat (2) step();
        fu_avail = '1; repeat (2) step();

        // R10: flush the younger half
        cur_req = "R10";
        fu_avail = '0;
        for (int i = 0; i < 5; i++) begin put(i % NCLS, 1, 1, 1, 1, i); step(); end
        flush_valid = 1'b1; flush_age = AGE_W'(next_age - 3); step();
        fu_avail = '1; repeat (3) step();

        // mixed traffic over all requirements
        cur_req = "R2/R4/R6/R8/R9/R10 mix";
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 10 < 6)
                put($urandom % NCLS, $urandom % 16, $urandom % 2, $urandom % 16,
                    $urandom % 2, $urandom % 64);
            for (int b = 0; b < NB; b++) if ($urandom % 2) cast(b, $urandom % 16);
            fu_avail = NCLS'($urandom);
            if ($urandom % 25 == 0) begin
                flush_valid = 1'b1;
                flush_age = AGE_W'(next_age - 1 - ($urandom % 4));
            end
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule